// File: doc/BRIEF.md
# CAN Configuration Lockout Controller

This block guards the configuration mode of a CAN controller. It sits between the CPU register port and the protocol engine. Software asks for configuration mode by setting a mode bit. The block grants the request only when the engine reports no reception, transmission or arbitration in progress, or when the engine raises an error while the request is waiting. While configuration mode is active, the CPU may rewrite a 16-byte configuration region and the two error counters. Outside configuration mode those writes are silently dropped. Reads are allowed at all times.

When configuration mode is left, the block does not enable the engine at once. It first counts 11 consecutive recessive bits on the sampled receive line, and a dominant bit restarts the count. When the engine reports bus-off, the block drops out of configuration mode, signals recovery and refuses every control write. When bus-off ends, it goes through the same 11-bit idle wait. An all-zero bit timing setting forces configuration mode and keeps the block in it.

The controller has four states:
- `ST_CONFIG`: configuration mode; the mode bit reads 1.
- `ST_SYNC`: counting idle bits.
- `ST_ACTIVE`: bus enabled.
- `ST_BUSOFF`: recovery.

The transitions are:
- reset → `ST_CONFIG`
- `ST_CONFIG` → `ST_SYNC` on an accepted clear of the mode bit
- `ST_SYNC` → `ST_ACTIVE` when the 11th consecutive recessive bit arrives
- `ST_SYNC`/`ST_ACTIVE` → `ST_CONFIG` on a granted request, a soft reset or zero timing
- any state → `ST_BUSOFF` when bus-off is raised
- `ST_BUSOFF` → `ST_SYNC` when bus-off falls

A waiting request is held in a separate pending flag. That flag is cleared by a grant, by reset and by bus-off.

Top module: `can_cfg_lockout`

## Requirements
- R1: After reset the control byte (address 0x10) reads 0x01, with the mode bit at bit 0. The bus enable is low. All configuration bytes and both error counters read 0x00.
- R2: A control write with bit 0 set while the engine is idle makes the mode bit read 1 after that clock edge.
- R3: While the receive, transmit or arbitration busy input is high, a request keeps the mode bit at 0. The mode bit reads 1 after the first clock edge at which all three are low.
- R4: A protocol error input seen while a request is pending grants configuration mode at that edge, even when the engine is busy.
- R5: CPU writes to configuration bytes 0x00–0x0F are discarded while the mode bit reads 0. Those bytes can be read at any time.
- R6: The transmit error counter (0x11) and the receive error counter (0x12) take CPU writes only while the mode bit reads 1.
- R7: A high bus-off input clears the mode bit and raises the recovery output. Bit 7 of the control byte shows bus-off. Every control write is ignored while bus-off is high. When bus-off falls, the block enters the idle-bit wait.
- R8: A control write with bit 1 set (soft reset, which reads back 0) forces the mode bit to 1 after that edge, whatever the engine activity.
- R9: When configuration bytes 0 and 1 (the bit timing pair) are both 0x00, a control write that clears bit 0 is ignored and the mode bit stays 1.
- R10: After configuration mode or bus-off is left, the bus enable rises only on the 11th consecutive bit-tick sample with the receive bit recessive (1). A dominant (0) sample restarts the count.
- R11: The bus enable is never high while the mode bit is 1 or before the idle count completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| cpu_wr_en | input | 1 | CPU write strobe |
| cpu_rd_en | input | 1 | CPU read strobe |
| cpu_addr | input | 5 | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational, 0 when no read |
| eng_rx_busy | input | 1 | Engine is receiving a frame |
| eng_tx_busy | input | 1 | Engine is transmitting a frame |
| eng_arb_busy | input | 1 | Engine is in arbitration |
| eng_error | input | 1 | Engine detected a protocol error |
| bus_off_i | input | 1 | Engine bus-off status |
| rx_bit_i | input | 1 | Sampled receive bit, 1 = recessive |
| bit_tick_i | input | 1 | One pulse per sampled bit |
| init_o | output | 1 | Configuration mode bit as software sees it |
| bus_en_o | output | 1 | Enables the protocol engine |
| recover_o | output | 1 | Bus-off recovery in progress |
| cfg_bytes_o | output | 128 | Configuration region, byte i at bits 8i+7:8i |
| tec_o | output | 8 | Transmit error counter |
| rec_o | output | 8 | Receive error counter |

## Verification
The entry request is tried with four kinds of engine activity around it:
- With the engine idle, it shows whether the grant is immediate.
- With receive busy and then transmit busy held, it shows whether every activity source delays the grant and whether the grant follows the first fully idle edge.
- With an error pulse during arbitration, it separates the error path from the idle path.
- With a soft reset during busy, it separates the unconditional path from both.

The idle-bit wait is fed a dominant bit partway through the count, which separates a restarting counter from a cumulative one. Bus-off is applied while control and configuration writes are attempted, so a leaking lockout would show in the readback.

// File: rtl/can_lock_pkg.sv
`timescale 1ns/1ps
package can_lock_pkg;

    typedef enum logic [1:0] {
        ST_CONFIG = 2'd0,
        ST_SYNC   = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_BUSOFF = 2'd3
    } lock_state_e;

    localparam int CTRL_INIT_BIT = 0;
    localparam int CTRL_SRST_BIT = 1;
    localparam int CTRL_BOFF_BIT = 7;

endpackage

// File: rtl/can_lock_idle.sv
`timescale 1ns/1ps
module can_lock_idle #(
    parameter int IDLE_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_clr,
    input  logic bit_tick,
    input  logic rx_recessive,
    output logic idle_done
);
    localparam int CW = $clog2(IDLE_BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(IDLE_BITS - 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (hold_clr) begin
            run_cnt <= '0;
        end else if (bit_tick) begin
            if (!rx_recessive) begin
                run_cnt <= '0;
            end else if (run_cnt == LAST) begin
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    assign idle_done = !hold_clr && bit_tick && rx_recessive && (run_cnt == LAST);

endmodule

// File: rtl/can_lock_regs.sv
`timescale 1ns/1ps
module can_lock_regs
    import can_lock_pkg::*;
#(
    parameter int CFG_BYTES = 16,
    parameter int ADDR_W    = 5,
    parameter int TIM0_IDX  = 0,
    parameter int TIM1_IDX  = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [7:0]             wdata,
    input  logic                   init_flag,
    input  logic                   bus_off_flag,
    output logic [CFG_BYTES*8-1:0] cfg_flat,
    output logic [7:0]             tec,
    output logic [7:0]             rec,
    output logic [7:0]             rdata,
    output logic                   timing_zero
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CFG_BYTES);
    localparam logic [ADDR_W-1:0] TEC_ADDR  = ADDR_W'(CFG_BYTES + 1);
    localparam logic [ADDR_W-1:0] REC_ADDR  = ADDR_W'(CFG_BYTES + 2);

    logic [7:0] cfg_mem [CFG_BYTES];
    logic [7:0] ctrl_view;

    for (genvar gi = 0; gi < CFG_BYTES; gi++) begin : g_cfg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_mem[gi] <= 8'h00;
            end else if (init_flag && wr_en && (addr == ADDR_W'(gi))) begin
                cfg_mem[gi] <= wdata;
            end
        end
        assign cfg_flat[gi*8 +: 8] = cfg_mem[gi];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tec <= 8'h00;
            rec <= 8'h00;
        end else if (init_flag && wr_en) begin
            if (addr == TEC_ADDR) tec <= wdata;
            if (addr == REC_ADDR) rec <= wdata;
        end
    end

    assign timing_zero = (cfg_mem[TIM0_IDX] == 8'h00) && (cfg_mem[TIM1_IDX] == 8'h00);

    always_comb begin
        ctrl_view = 8'h00;
        ctrl_view[CTRL_INIT_BIT] = init_flag;
        ctrl_view[CTRL_BOFF_BIT] = bus_off_flag;
    end

    always_comb begin
        rdata = 8'h00;
        if (rd_en) begin
            for (int i = 0; i < CFG_BYTES; i++) begin
                if (addr == ADDR_W'(i)) rdata = cfg_mem[i];
            end
            if (addr == CTRL_ADDR) rdata = ctrl_view;
            if (addr == TEC_ADDR)  rdata = tec;
            if (addr == REC_ADDR)  rdata = rec;
        end
    end

endmodule

// File: rtl/can_lock_fsm.sv
`timescale 1ns/1ps
module can_lock_fsm
    import can_lock_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic        wr_init_bit,
    input  logic        wr_srst_bit,
    input  logic        rx_busy,
    input  logic        tx_busy,
    input  logic        arb_busy,
    input  logic        proto_err,
    input  logic        bus_off,
    input  logic        timing_zero,
    input  logic        idle_done,
    output lock_state_e state_q,
    output logic        init_flag,
    output logic        bus_en,
    output logic        recovering
);
    lock_state_e state_d;
    logic        req_pend, pend_d;
    logic        busy, ctl_ok, ask, soft_rst;

    assign busy     = rx_busy | tx_busy | arb_busy;
    assign ctl_ok   = ctrl_wr && !bus_off;
    assign soft_rst = ctl_ok && wr_srst_bit;
    assign ask      = req_pend || (ctl_ok && wr_init_bit);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_CONFIG;
            req_pend <= 1'b0;
        end else begin
            state_q  <= state_d;
            req_pend <= pend_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        pend_d  = req_pend;
        if (bus_off) begin
            state_d = ST_BUSOFF;
            pend_d  = 1'b0;
        end else begin
            unique case (state_q)
                ST_CONFIG: begin
                    pend_d = 1'b0;
                    if (ctl_ok && !wr_srst_bit && !wr_init_bit && !timing_zero) begin
                        state_d = ST_SYNC;
                    end
                end
                ST_SYNC, ST_ACTIVE: begin
                    if (soft_rst || timing_zero) begin
                        state_d = ST_CONFIG;
                        pend_d  = 1'b0;
                    end else if (ask && (!busy || proto_err)) begin
                        state_d = ST_CONFIG;
                        pend_d  = 1'b0;
                    end else if (ask) begin
                        pend_d  = 1'b1;
                    end else if ((state_q == ST_SYNC) && idle_done) begin
                        state_d = ST_ACTIVE;
                    end
                end
                ST_BUSOFF: begin
                    state_d = ST_SYNC;
                    pend_d  = 1'b0;
                end
                default: state_d = ST_CONFIG;
            endcase
        end
    end

    // outputs
    always_comb begin
        init_flag  = (state_q == ST_CONFIG);
        bus_en     = (state_q == ST_ACTIVE);
        recovering = (state_q == ST_BUSOFF);
    end

endmodule

// File: rtl/can_cfg_lockout.sv
`timescale 1ns/1ps
module can_cfg_lockout
    import can_lock_pkg::*;
#(
    parameter int CFG_BYTES = 16,
    parameter int ADDR_W    = 5,
    parameter int IDLE_BITS = 11,
    parameter int TIM0_IDX  = 0,
    parameter int TIM1_IDX  = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cpu_wr_en,
    input  logic                   cpu_rd_en,
    input  logic [ADDR_W-1:0]      cpu_addr,
    input  logic [7:0]             cpu_wdata,
    output logic [7:0]             cpu_rdata,
    input  logic                   eng_rx_busy,
    input  logic                   eng_tx_busy,
    input  logic                   eng_arb_busy,
    input  logic                   eng_error,
    input  logic                   bus_off_i,
    input  logic                   rx_bit_i,
    input  logic                   bit_tick_i,
    output logic                   init_o,
    output logic                   bus_en_o,
    output logic                   recover_o,
    output logic [CFG_BYTES*8-1:0] cfg_bytes_o,
    output logic [7:0]             tec_o,
    output logic [7:0]             rec_o
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CFG_BYTES);

    lock_state_e state_q;
    logic        init_flag, timing_zero, idle_done, ctrl_wr;

    assign ctrl_wr = cpu_wr_en && (cpu_addr == CTRL_ADDR);

    can_lock_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (ctrl_wr),
        .wr_init_bit (cpu_wdata[CTRL_INIT_BIT]),
        .wr_srst_bit (cpu_wdata[CTRL_SRST_BIT]),
        .rx_busy     (eng_rx_busy),
        .tx_busy     (eng_tx_busy),
        .arb_busy    (eng_arb_busy),
        .proto_err   (eng_error),
        .bus_off     (bus_off_i),
        .timing_zero (timing_zero),
        .idle_done   (idle_done),
        .state_q     (state_q),
        .init_flag   (init_flag),
        .bus_en      (bus_en_o),
        .recovering  (recover_o)
    );

    can_lock_idle #(.IDLE_BITS(IDLE_BITS)) u_idle (
        .clk          (clk),
        .rst_n        (rst_n),
        .hold_clr     (state_q != ST_SYNC),
        .bit_tick     (bit_tick_i),
        .rx_recessive (rx_bit_i),
        .idle_done    (idle_done)
    );

    can_lock_regs #(
        .CFG_BYTES (CFG_BYTES),
        .ADDR_W    (ADDR_W),
        .TIM0_IDX  (TIM0_IDX),
        .TIM1_IDX  (TIM1_IDX)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (cpu_wr_en),
        .rd_en        (cpu_rd_en),
        .addr         (cpu_addr),
        .wdata        (cpu_wdata),
        .init_flag    (init_flag),
        .bus_off_flag (bus_off_i),
        .cfg_flat     (cfg_bytes_o),
        .tec          (tec_o),
        .rec          (rec_o),
        .rdata        (cpu_rdata),
        .timing_zero  (timing_zero)
    );

    assign init_o = init_flag;

endmodule

// File: rtl/can_lock_chk.sv
`timescale 1ns/1ps
module can_lock_chk #(
    parameter int CFG_BYTES = 16,
    parameter int ADDR_W    = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cpu_wr_en,
    input logic [ADDR_W-1:0]      cpu_addr,
    input logic                   eng_rx_busy,
    input logic                   eng_tx_busy,
    input logic                   eng_arb_busy,
    input logic                   eng_error,
    input logic                   bus_off_i,
    input logic                   init_o,
    input logic                   bus_en_o,
    input logic                   recover_o,
    input logic                   req_pend,
    input logic                   timing_zero,
    input logic [CFG_BYTES*8-1:0] cfg_bytes_o,
    input logic [7:0]             tec_o,
    input logic [7:0]             rec_o
);
    logic busy, ctrl_touch;
    assign busy       = eng_rx_busy | eng_tx_busy | eng_arb_busy;
    assign ctrl_touch = cpu_wr_en && (cpu_addr == ADDR_W'(CFG_BYTES));

    AST_BUSY_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_o && busy && !eng_error && !ctrl_touch) |=> !init_o); // R3

    AST_ERROR_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_o && req_pend && eng_error && !bus_off_i) |=> init_o); // R4

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr_en && (cpu_addr < ADDR_W'(CFG_BYTES)) && !init_o) |=> $stable(cfg_bytes_o)); // R5

    AST_ERRCNT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !init_o |=> ($stable(tec_o) && $stable(rec_o))); // R6

    AST_BUSOFF_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_off_i |=> (!init_o && recover_o && !bus_en_o)); // R7

    AST_ZERO_TIMING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (init_o && timing_zero && !bus_off_i) |=> init_o); // R9

    AST_ENABLE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        init_o |-> !bus_en_o); // R11

endmodule

bind can_cfg_lockout can_lock_chk #(.CFG_BYTES(CFG_BYTES), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_wr_en    (cpu_wr_en),
    .cpu_addr     (cpu_addr),
    .eng_rx_busy  (eng_rx_busy),
    .eng_tx_busy  (eng_tx_busy),
    .eng_arb_busy (eng_arb_busy),
    .eng_error    (eng_error),
    .bus_off_i    (bus_off_i),
    .init_o       (init_o),
    .bus_en_o     (bus_en_o),
    .recover_o    (recover_o),
    .req_pend     (u_fsm.req_pend),
    .timing_zero  (timing_zero),
    .cfg_bytes_o  (cfg_bytes_o),
    .tec_o        (tec_o),
    .rec_o        (rec_o)
);

// File: tb/tb_can_cfg_lockout.sv
`timescale 1ns/1ps
module tb_can_cfg_lockout;

    localparam logic [4:0] A_CTRL = 5'h10;
    localparam logic [4:0] A_TEC  = 5'h11;
    localparam logic [4:0] A_REC  = 5'h12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0]   addr = '0;
    logic [7:0]   wdata = '0;
    logic [7:0]   rdata;
    logic         rx_act = 1'b0, tx_act = 1'b0, arb_act = 1'b0, perr = 1'b0;
    logic         boff = 1'b0, rxb = 1'b1, tick = 1'b0;
    logic         init_o, bus_en, recov;
    logic [127:0] cfg_bytes;
    logic [7:0]   tec, rec;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    can_cfg_lockout dut (
        .clk (clk), .rst_n (rst_n),
        .cpu_wr_en (wr_en), .cpu_rd_en (rd_en), .cpu_addr (addr),
        .cpu_wdata (wdata), .cpu_rdata (rdata),
        .eng_rx_busy (rx_act), .eng_tx_busy (tx_act), .eng_arb_busy (arb_act),
        .eng_error (perr), .bus_off_i (boff), .rx_bit_i (rxb), .bit_tick_i (tick),
        .init_o (init_o), .bus_en_o (bus_en), .recover_o (recov),
        .cfg_bytes_o (cfg_bytes), .tec_o (tec), .rec_o (rec)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1;
        d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic send_bits(input int n, input logic v);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1; rxb = v;
            @(negedge clk);
            tick = 1'b0; rxb = 1'b1;
        end
    endtask

    task automatic resync();
        wr(A_CTRL, 8'h00);
        send_bits(11, 1'b1);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(A_CTRL, v); chk("R1 ctrl after reset", v, 8'h01);
        chk("R1 bus_en after reset", {7'b0, bus_en}, 8'h00);
        rd(5'h05, v);  chk("R1 cfg byte 5 after reset", v, 8'h00);
        rd(A_TEC, v);  chk("R1 tec after reset", v, 8'h00);
    endtask

    task automatic t_exit_blocked();
        logic [7:0] v;
        wr(A_CTRL, 8'h00);
        rd(A_CTRL, v); chk("R9 exit blocked by zero timing", v, 8'h01);
    endtask

    task automatic t_program();
        logic [7:0] v;
        wr(5'h00, 8'h03); wr(5'h01, 8'h1C); wr(5'h05, 8'hA5);
        wr(A_TEC, 8'h10); wr(A_REC, 8'h20);
        rd(5'h05, v); chk("R5 cfg write in config mode", v, 8'hA5);
        rd(A_TEC, v); chk("R6 tec write in config mode", v, 8'h10);
        rd(A_REC, v); chk("R6 rec write in config mode", v, 8'h20);
    endtask

    task automatic t_sync();
        logic [7:0] v;
        wr(A_CTRL, 8'h00);
        rd(A_CTRL, v); chk("R10 mode bit cleared", v, 8'h00);
        chk("R11 bus_en low during wait", {7'b0, bus_en}, 8'h00);
        send_bits(5, 1'b1);
        send_bits(1, 1'b0);
        send_bits(10, 1'b1);
        chk("R10 dominant restarts count", {7'b0, bus_en}, 8'h00);
        send_bits(1, 1'b1);
        chk("R10 enable after 11 recessive", {7'b0, bus_en}, 8'h01);
    endtask

    task automatic t_locked();
        logic [7:0] v;
        wr(5'h05, 8'h5A);
        rd(5'h05, v); chk("R5 cfg write discarded", v, 8'hA5);
        wr(A_TEC, 8'h77);
        rd(A_TEC, v); chk("R6 tec write discarded", v, 8'h10);
        wr(A_REC, 8'h66);
        rd(A_REC, v); chk("R6 rec write discarded", v, 8'h20);
    endtask

    task automatic t_entry_idle();
        logic [7:0] v;
        wr(A_CTRL, 8'h01);
        rd(A_CTRL, v); chk("R2 idle request granted", v, 8'h01);
        chk("R11 bus_en low in config", {7'b0, bus_en}, 8'h00);
        resync();
    endtask

    task automatic t_entry_busy();
        logic [7:0] v;
        @(negedge clk); rx_act = 1'b1;
        wr(A_CTRL, 8'h01);
        rd(A_CTRL, v); chk("R3 held while receiving", v, 8'h00);
        repeat (3) @(negedge clk);
        rd(A_CTRL, v); chk("R3 still held", v, 8'h00);
        rx_act = 1'b0; tx_act = 1'b1;
        repeat (2) @(negedge clk);
        rd(A_CTRL, v); chk("R3 held while transmitting", v, 8'h00);
        tx_act = 1'b0;
        @(negedge clk);
        rd(A_CTRL, v); chk("R3 granted when idle", v, 8'h01);
        resync();
    endtask

    task automatic t_entry_err();
        logic [7:0] v;
        @(negedge clk); arb_act = 1'b1;
        wr(A_CTRL, 8'h01);
        rd(A_CTRL, v); chk("R3 held in arbitration", v, 8'h00);
        @(negedge clk); perr = 1'b1;
        @(negedge clk); perr = 1'b0;
        rd(A_CTRL, v); chk("R4 error grants request", v, 8'h01);
        arb_act = 1'b0;
        resync();
    endtask

    task automatic t_soft();
        logic [7:0] v;
        @(negedge clk); rx_act = 1'b1;
        wr(A_CTRL, 8'h02);
        rd(A_CTRL, v); chk("R8 soft reset forces mode", v, 8'h01);
        rx_act = 1'b0;
    endtask

    task automatic t_zero_timing();
        logic [7:0] v;
        wr(5'h00, 8'h00); wr(5'h01, 8'h00);
        wr(A_CTRL, 8'h00);
        rd(A_CTRL, v); chk("R9 zero timing keeps mode", v, 8'h01);
        wr(5'h00, 8'h03); wr(5'h01, 8'h1C);
    endtask

    task automatic t_busoff();
        logic [7:0] v;
        @(negedge clk); boff = 1'b1;
        @(negedge clk);
        rd(A_CTRL, v); chk("R7 bus-off clears mode", v, 8'h80);
        chk("R7 recovery raised", {7'b0, recov}, 8'h01);
        wr(A_CTRL, 8'h01);
        rd(A_CTRL, v); chk("R7 set ignored in bus-off", v, 8'h80);
        wr(A_CTRL, 8'h02);
        rd(A_CTRL, v); chk("R7 soft reset ignored in bus-off", v, 8'h80);
        wr(5'h05, 8'h11);
        rd(5'h05, v); chk("R5 cfg locked in bus-off", v, 8'hA5);
        boff = 1'b0;
        @(negedge clk);
        rd(A_CTRL, v); chk("R7 bus-off released", v, 8'h00);
        chk("R7 recovery dropped", {7'b0, recov}, 8'h00);
        send_bits(10, 1'b1);
        chk("R10 wait after bus-off", {7'b0, bus_en}, 8'h00);
        send_bits(1, 1'b1);
        chk("R7 enable after recovery", {7'b0, bus_en}, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_exit_blocked();
        t_program();
        t_sync();
        t_locked();
        t_entry_idle();
        t_entry_busy();
        t_entry_err();
        t_soft();
        t_zero_timing();
        t_busoff();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule